// File: doc/BRIEF.md
# Multimode 24-bit Count Engine

This block is a synchronous 24-bit counter that advances on one-cycle up and down count enables. It can count in plain binary, as six BCD digits, or as a 24-hour time of day (HH:MM:SS packed as six BCD digits). A separately written 24-bit preset register feeds the counter on a load command. The same preset serves as the comparison value, and in divide-by-N mode it is also the reload value.

Carry and borrow pulse for one cycle when the count wraps. Two toggle flags flip on each carry and on each borrow, so a slow poller can tell that a wrap happened. A compare output reports that the count equals the preset. It is held off after a load until the count has moved at least once. Two further static mode inputs select divide-by-N reload and a cycle-once mode that stops counting after the first wrap. The surrounding logic owns the bus access, the quadrature decoding and any readback latching, and drives this block through plain control inputs.

Top module: `mcount_core`

## Requirements
- R1: After reset (rst_n low at a clock edge) count_q, carry, borrow, cmp_hit, cy_tog and bw_tog are all 0, and counting is enabled.
- R2: A preset_we pulse stores preset_d. A load pulse copies the stored preset into count_q at the next edge, and it takes priority over any count enable in the same cycle. If preset_we and load arrive together, the load uses the previously stored preset.
- R3: With bcd_sel=0 and hr24_sel=0, an up step adds 1 and a down step subtracts 1, modulo 2^24.
- R4: With bcd_sel=1 and hr24_sel=0, each of the six 4-bit digits (digit 0 in bits 3:0) counts 0..9. A digit wraps 9 to 0 going up and 0 to 9 going down, passing a carry or borrow to the next digit. The full count wraps between 999999 and 000000.
- R5: With hr24_sel=1, the value counts as HH:MM:SS in BCD, with hours in bits 23:16, minutes in bits 15:8 and seconds in bits 7:0. It runs from 00:00:00 to 23:59:59 and wraps in both directions, and it ignores bcd_sel.
- R6: carry is high for exactly the one cycle after an up step that wraps the count. borrow is high for exactly the one cycle after a down step that wraps it. They are never high together.
- R7: cy_tog inverts at every carry pulse and bw_tog inverts at every borrow pulse.
- R8: If up_en and dn_en are both high in a cycle, the count does not change and no carry or borrow is produced.
- R9: cmp_hit is high when count_q equals the stored preset, but only once a count step has been accepted since the last load. Right after a load it is low even though the two are equal.
- R10: With divn_sel=1, a step that would wrap the count instead reloads the stored preset and still produces the carry or borrow. With preset 3 counting down, the sequence is 3, 2, 1, 0, 3, 2.
- R11: With once_sel=1, a carry or borrow disables further count steps until the next load, which enables counting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_en | input | 1 | One-cycle up-count enable |
| dn_en | input | 1 | One-cycle down-count enable |
| load | input | 1 | Copy the stored preset into the count |
| preset_we | input | 1 | Store preset_d into the preset register |
| preset_d | input | 24 | Preset write data |
| bcd_sel | input | 1 | Decimal digit encoding (static) |
| hr24_sel | input | 1 | Time-of-day encoding, overrides bcd_sel (static) |
| divn_sel | input | 1 | Reload the preset on wrap (static) |
| once_sel | input | 1 | Stop after the first wrap (static) |
| count_q | output | 24 | Current count |
| carry | output | 1 | One-cycle up-wrap pulse |
| borrow | output | 1 | One-cycle down-wrap pulse |
| cmp_hit | output | 1 | Count equals preset, armed by a count step |
| cy_tog | output | 1 | Inverts on each carry |
| bw_tog | output | 1 | Inverts on each borrow |

## Verification
The counting path is driven from values placed next to each wrap point. All-ones and all-zeros test binary overflow. 999999, 000000 and 000109 show whether a decimal digit ripples into its neighbour. 23:59:59, 00:00:00, 19:59:59 and 20:00:00 separate the combined hour limit from the plain digit limits. A fixed down sequence from preset 3, plus an up run ending at all-ones, shows whether a wrap reloads the preset or falls through to the natural wrap value. Load-then-step patterns tell the armed compare apart from a plain equality. Stepping after a wrap in cycle-once mode, including in the opposite direction, shows that the stop holds until the next load.

// File: rtl/mcount_pkg.sv
// Package: shared widths and types for the multimode count engine.
// Assumes a count of six 4-bit digits; the time-of-day encoding relies on it.
package mcount_pkg;
    localparam int unsigned CNT_W = 24;
    localparam int unsigned DIG_W = 4;
    localparam int unsigned N_DIG = CNT_W / DIG_W;
    localparam int unsigned HR_LO = 4 * DIG_W;      // hours-units digit base bit
    localparam int unsigned HR_HI = 5 * DIG_W;      // hours-tens digit base bit

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DIG_W-1:0] dig_t;

    typedef enum logic [1:0] {
        ENC_BIN  = 2'd0,
        ENC_BCD  = 2'd1,
        ENC_HR24 = 2'd2
    } enc_e;

    // Resolve the mode inputs: time-of-day beats decimal, decimal beats binary.
    function automatic enc_e pick_enc(input logic bcd, input logic hr24);
        if (hr24)     return ENC_HR24;
        else if (bcd) return ENC_BCD;
        else          return ENC_BIN;
    endfunction
endpackage

// File: rtl/mcount_step.sv
// mcount_step: purely combinational next-value logic for one count step.
// Given the current count and a direction, it returns the stepped value and
// whether the step wraps the whole count. Assumes the caller applies the
// result only when exactly one enable is active.
module mcount_step
    import mcount_pkg::*;
(
    input  cnt_t       cur,
    input  logic       dir_up,
    input  enc_e       enc,
    output cnt_t       nxt,
    output logic       wrap
);
    localparam dig_t LIM_DEC = dig_t'(9);
    localparam dig_t LIM_SIX = dig_t'(5);
    localparam logic [7:0] HR_MAX = 8'd23;

    logic [N_DIG:0] chain;
    cnt_t           dec_val;

    assign chain[0] = 1'b1;

    // One decimal lane per digit; the ripple chain carries the step upward.
    for (genvar g = 0; g < N_DIG; g++) begin : g_lane
        dig_t lim;
        dig_t dv;
        dig_t nv;
        logic co;

        assign dv  = cur[g*DIG_W +: DIG_W];
        assign lim = ((enc == ENC_HR24) && ((g == 1) || (g == 3))) ? LIM_SIX : LIM_DEC;

        // Step this digit when the lower digits pass a carry or borrow in.
        always_comb begin
            nv = dv;
            co = 1'b0;
            if (chain[g]) begin
                if (dir_up) begin
                    if (dv >= lim) begin
                        nv = '0;
                        co = 1'b1;
                    end else begin
                        nv = dv + dig_t'(1);
                    end
                end else begin
                    if (dv == '0) begin
                        nv = lim;
                        co = 1'b1;
                    end else begin
                        nv = dv - dig_t'(1);
                    end
                end
            end
        end

        assign chain[g+1]                = co;
        assign dec_val[g*DIG_W +: DIG_W] = nv;
    end

    // Hours run as one 0..23 field so the tens digit sets the units limit.
    logic [7:0] hr_cur;
    logic [7:0] hr_nxt;
    logic       hr_wrap;
    dig_t       hr_tens;
    dig_t       hr_units;

    assign hr_cur = ({4'd0, cur[HR_HI +: DIG_W]} * 8'd10) + {4'd0, cur[HR_LO +: DIG_W]};

    // Step the hour field when the minutes pass a carry or borrow in.
    always_comb begin
        hr_nxt  = hr_cur;
        hr_wrap = 1'b0;
        if (chain[4]) begin
            if (dir_up) begin
                if (hr_cur >= HR_MAX) begin
                    hr_nxt  = 8'd0;
                    hr_wrap = 1'b1;
                end else begin
                    hr_nxt  = hr_cur + 8'd1;
                end
            end else begin
                if (hr_cur == 8'd0) begin
                    hr_nxt  = HR_MAX;
                    hr_wrap = 1'b1;
                end else begin
                    hr_nxt  = hr_cur - 8'd1;
                end
            end
        end
    end

    assign hr_tens  = dig_t'(hr_nxt / 8'd10);
    assign hr_units = dig_t'(hr_nxt % 8'd10);

    // Select the result for the active encoding.
    always_comb begin
        case (enc)
            ENC_HR24: begin
                if (chain[4]) nxt = {hr_tens, hr_units, dec_val[HR_LO-1:0]};
                else          nxt = {cur[CNT_W-1:HR_LO], dec_val[HR_LO-1:0]};
                wrap = hr_wrap;
            end
            ENC_BCD: begin
                nxt  = dec_val;
                wrap = chain[N_DIG];
            end
            default: begin
                nxt  = dir_up ? (cur + cnt_t'(1)) : (cur - cnt_t'(1));
                wrap = dir_up ? (&cur) : (~|cur);
            end
        endcase
    end
endmodule

// File: rtl/mcount_gate.sv
// mcount_gate: decides whether a requested step is taken and tracks the
// compare arming. Assumes step_req is high only when exactly one enable is
// active, and that wrap_taken is already qualified by go.
module mcount_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step_req,
    input  logic once_sel,
    input  logic wrap_taken,
    output logic go,
    output logic arm
);
    logic run_q;
    logic arm_q;

    assign go  = step_req && !load && (!once_sel || run_q);
    assign arm = arm_q;

    // Run flag: set by load, cleared by a wrap (used only in cycle-once mode).
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b1;
        else if (load)       run_q <= 1'b1;
        else if (wrap_taken) run_q <= 1'b0;
    end

    // Compare arm: cleared by load, set by the first accepted step after it.
    always_ff @(posedge clk) begin
        if (!rst_n)    arm_q <= 1'b0;
        else if (load) arm_q <= 1'b0;
        else if (go)   arm_q <= 1'b1;
    end
endmodule

// File: rtl/mcount_core.sv
// mcount_core: top of the multimode 24-bit count engine. Holds the preset and
// count registers, the wrap pulses and the toggle flags. Mode inputs are
// assumed static while counting; count enables are single-cycle pulses.
module mcount_core
    import mcount_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic             load,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_d,
    input  logic             bcd_sel,
    input  logic             hr24_sel,
    input  logic             divn_sel,
    input  logic             once_sel,
    output logic [CNT_W-1:0] count_q,
    output logic             carry,
    output logic             borrow,
    output logic             cmp_hit,
    output logic             cy_tog,
    output logic             bw_tog
);
    cnt_t cnt_r;
    cnt_t pre_q;
    cnt_t step_val;
    logic step_wrap;
    logic step_req;
    logic go;
    logic arm;
    logic wrap_taken;
    logic carry_r;
    logic borrow_r;
    logic cyt_r;
    logic bwt_r;
    enc_e enc;

    assign enc        = pick_enc(bcd_sel, hr24_sel);
    assign step_req   = up_en ^ dn_en;
    assign wrap_taken = go && step_wrap;

    mcount_step u_step (
        .cur    (cnt_r),
        .dir_up (up_en),
        .enc    (enc),
        .nxt    (step_val),
        .wrap   (step_wrap)
    );

    mcount_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step_req   (step_req),
        .once_sel   (once_sel),
        .wrap_taken (wrap_taken),
        .go         (go),
        .arm        (arm)
    );

    // Preset register: written on request, read by load, compare and reload.
    always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (preset_we) pre_q <= preset_d;
    end

    // Count register: load first, then a taken step (reloading on wrap if dividing).
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_r <= '0;
        else if (load)                   cnt_r <= pre_q;
        else if (wrap_taken && divn_sel) cnt_r <= pre_q;
        else if (go)                     cnt_r <= step_val;
    end

    // Wrap pulses: high for the single cycle following a wrapping step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_r  <= 1'b0;
            borrow_r <= 1'b0;
        end else begin
            carry_r  <= wrap_taken && up_en;
            borrow_r <= wrap_taken && dn_en;
        end
    end

    // Toggle flags: flip in step with each carry or borrow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyt_r <= 1'b0;
            bwt_r <= 1'b0;
        end else begin
            if (wrap_taken && up_en) cyt_r <= !cyt_r;
            if (wrap_taken && dn_en) bwt_r <= !bwt_r;
        end
    end

    assign count_q = cnt_r;
    assign carry   = carry_r;
    assign borrow  = borrow_r;
    assign cy_tog  = cyt_r;
    assign bw_tog  = bwt_r;
    assign cmp_hit = arm && (cnt_r == pre_q);
endmodule

// File: rtl/mcount_chk.sv
// mcount_chk: temporal checks on the count engine, bound to mcount_core.
module mcount_chk
    import mcount_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             up_en,
    input logic             dn_en,
    input logic             load,
    input logic             preset_we,
    input logic             divn_sel,
    input logic             once_sel,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] pre_q,
    input logic             carry,
    input logic             borrow,
    input logic             cmp_hit,
    input logic             cy_tog,
    input logic             bw_tog
);
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(pre_q)));

    a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry && borrow));

    a_r7_cy_flip: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (cy_tog != $past(cy_tog)));

    a_r7_bw_flip: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |-> (bw_tog != $past(bw_tog)));

    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && dn_en && !load) |=> (count_q == $past(count_q)));

    a_r9_no_cmp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !cmp_hit);

    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (borrow && divn_sel && !$past(preset_we)) |-> (count_q == pre_q));

    a_r11_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (once_sel && (carry || borrow) && !load) |=> (count_q == $past(count_q)));
endmodule

bind mcount_core mcount_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_en     (up_en),
    .dn_en     (dn_en),
    .load      (load),
    .preset_we (preset_we),
    .divn_sel  (divn_sel),
    .once_sel  (once_sel),
    .count_q   (count_q),
    .pre_q     (pre_q),
    .carry     (carry),
    .borrow    (borrow),
    .cmp_hit   (cmp_hit),
    .cy_tog    (cy_tog),
    .bw_tog    (bw_tog)
);

// File: tb/sim_mcount_core.sv
module sim_mcount_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_en = 1'b0;
    logic        dn_en = 1'b0;
    logic        load = 1'b0;
    logic        preset_we = 1'b0;
    logic [23:0] preset_d = '0;
    logic        bcd_sel = 1'b0;
    logic        hr24_sel = 1'b0;
    logic        divn_sel = 1'b0;
    logic        once_sel = 1'b0;
    logic [23:0] count_q;
    logic        carry;
    logic        borrow;
    logic        cmp_hit;
    logic        cy_tog;
    logic        bw_tog;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mcount_core u0 (
        .clk(clk), .rst_n(rst_n), .up_en(up_en), .dn_en(dn_en), .load(load),
        .preset_we(preset_we), .preset_d(preset_d), .bcd_sel(bcd_sel),
        .hr24_sel(hr24_sel), .divn_sel(divn_sel), .once_sel(once_sel),
        .count_q(count_q), .carry(carry), .borrow(borrow), .cmp_hit(cmp_hit),
        .cy_tog(cy_tog), .bw_tog(bw_tog)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock of stimulus: drive at a falling edge, results visible at the next.
    task automatic cyc(input logic u, input logic d, input logic ld);
        up_en = u; dn_en = d; load = ld;
        @(negedge clk);
        up_en = 1'b0; dn_en = 1'b0; load = 1'b0;
    endtask

    task automatic set_preset(input logic [23:0] v);
        preset_we = 1'b1; preset_d = v;
        @(negedge clk);
        preset_we = 1'b0;
    endtask

    task automatic set_mode(input logic b, input logic h, input logic n, input logic o);
        bcd_sel = b; hr24_sel = h; divn_sel = n; once_sel = o;
    endtask

    task automatic t_reset;
        chk("R1 count", count_q, 24'h0);
        chk("R1 pulses", {22'd0, carry, borrow}, 24'h0);
        chk("R1 cmp", {23'd0, cmp_hit}, 24'h0);
        chk("R1 toggles", {22'd0, cy_tog, bw_tog}, 24'h0);
    endtask

    task automatic t_binary;
        set_mode(0, 0, 0, 0);
        set_preset(24'hFFFFFE); cyc(0, 0, 1);
        chk("R2 load", count_q, 24'hFFFFFE);
        cyc(1, 0, 0); chk("R3 up", count_q, 24'hFFFFFF);
        chk("R6 no early carry", {23'd0, carry}, 24'h0);
        cyc(1, 0, 0); chk("R3 overflow", count_q, 24'h000000);
        chk("R6 carry", {23'd0, carry}, 24'h1);
        chk("R7 cy_tog", {23'd0, cy_tog}, 24'h1);
        cyc(0, 0, 0); chk("R6 carry one cycle", {23'd0, carry}, 24'h0);
        cyc(0, 1, 0); chk("R3 underflow", count_q, 24'hFFFFFF);
        chk("R6 borrow", {23'd0, borrow}, 24'h1);
        chk("R7 bw_tog", {23'd0, bw_tog}, 24'h1);
        cyc(0, 1, 0); chk("R3 down", count_q, 24'hFFFFFE);
        chk("R6 borrow one cycle", {23'd0, borrow}, 24'h0);
    endtask

    task automatic t_cancel;
        cyc(1, 1, 0); chk("R8 both enables", count_q, 24'hFFFFFE);
        chk("R8 no pulse", {22'd0, carry, borrow}, 24'h0);
    endtask

    task automatic t_priority;
        set_preset(24'h123456);
        cyc(1, 0, 1); chk("R2 load beats step", count_q, 24'h123456);
        preset_we = 1'b1; preset_d = 24'h00ABCD;
        cyc(0, 0, 1); preset_we = 1'b0;
        chk("R2 load uses old preset", count_q, 24'h123456);
        cyc(0, 0, 1); chk("R2 new preset", count_q, 24'h00ABCD);
    endtask

    task automatic t_bcd;
        set_mode(1, 0, 0, 0);
        set_preset(24'h999999); cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R4 wrap up", count_q, 24'h000000);
        chk("R4 carry", {23'd0, carry}, 24'h1);
        cyc(0, 1, 0); chk("R4 wrap down", count_q, 24'h999999);
        chk("R4 borrow", {23'd0, borrow}, 24'h1);
        set_preset(24'h000109); cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R4 digit ripple", count_q, 24'h000110);
        cyc(0, 1, 0); chk("R4 digit ripple down", count_q, 24'h000109);
    endtask

    task automatic t_hr24;
        set_mode(1, 1, 0, 0);
        set_preset(24'h235959); cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R5 midnight", count_q, 24'h000000);
        chk("R5 carry", {23'd0, carry}, 24'h1);
        cyc(0, 1, 0); chk("R5 back", count_q, 24'h235959);
        chk("R5 borrow", {23'd0, borrow}, 24'h1);
        set_preset(24'h195959); cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R5 hour ripple", count_q, 24'h200000);
        cyc(0, 1, 0); chk("R5 hour ripple down", count_q, 24'h195959);
        set_preset(24'h000059); cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R5 seconds tens", count_q, 24'h000100);
    endtask

    task automatic t_compare;
        set_mode(0, 0, 0, 0);
        set_preset(24'h000005); cyc(0, 0, 1);
        chk("R9 suppressed after load", {23'd0, cmp_hit}, 24'h0);
        cyc(1, 0, 0); chk("R9 unequal", {23'd0, cmp_hit}, 24'h0);
        cyc(0, 1, 0); chk("R9 equal armed", {23'd0, cmp_hit}, 24'h1);
        cyc(0, 0, 1); chk("R9 reload suppresses", {23'd0, cmp_hit}, 24'h0);
    endtask

    task automatic t_divn;
        logic [23:0] seq [6] = '{24'd2, 24'd1, 24'd0, 24'd3, 24'd2, 24'd1};
        set_mode(0, 0, 1, 0);
        set_preset(24'd3); cyc(0, 0, 1);
        chk("R10 start", count_q, 24'd3);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 1, 0);
            chk("R10 down sequence", count_q, seq[i]);
            chk("R10 borrow on reload", {23'd0, borrow}, (i == 3) ? 24'h1 : 24'h0);
        end
        set_preset(24'hFFFFFD); cyc(0, 0, 1);
        cyc(1, 0, 0); cyc(1, 0, 0);
        cyc(1, 0, 0); chk("R10 up reload", count_q, 24'hFFFFFD);
        chk("R10 carry", {23'd0, carry}, 24'h1);
    endtask

    task automatic t_once;
        set_mode(0, 0, 0, 1);
        set_preset(24'hFFFFFE); cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R11 runs", count_q, 24'hFFFFFF);
        cyc(1, 0, 0); chk("R11 wraps", count_q, 24'h000000);
        chk("R11 carry", {23'd0, carry}, 24'h1);
        cyc(1, 0, 0); chk("R11 stopped up", count_q, 24'h000000);
        cyc(0, 1, 0); chk("R11 stopped down", count_q, 24'h000000);
        chk("R11 no borrow", {23'd0, borrow}, 24'h0);
        cyc(0, 0, 1);
        cyc(1, 0, 0); chk("R11 reenabled", count_q, 24'hFFFFFF);
        set_mode(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_binary;
        t_cancel;
        t_priority;
        t_bcd;
        t_hr24;
        t_compare;
        t_divn;
        t_once;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule